// File: doc/BRIEF.md
# Dual-mode SPI serial clock generator

This block derives the serial clock of an SPI master from the faster module clock. A single control word carries two divider fields and a select bit. With the select bit set, the serial clock runs at the module rate divided by an even linear factor. With it clear, the serial clock runs at the module rate divided by a power of two. Both laws are reduced to one half-period length, in module clocks, which a single counter then counts.

The transfer engine holds a run request high for as long as it wants serial clock periods. The block also has a bus enable. While the bus enable is low, the serial clock stays at its idle level. Between periods the clock idles at the level given by the polarity input. The block produces two strobes: a sample strobe and a shift strobe. Each strobe is one module clock wide and lines up with the serial clock edge it stands for. The phase input decides whether sampling uses the leading or the trailing edge of each period.

The block reads the divider fields, the polarity and the phase only when a run starts. The engine can therefore rewrite them during a transfer without breaking the periods in flight. A run that is asked to stop always finishes its current period first.

Top module: `spi_sck_gen`

## Requirements
- R1: When control word bit 12 is 1, the half period is (bits [7:0] + 1) module clocks, so the serial clock period is 2*(n+1) module clocks. Bits [11:8] have no effect in this mode.
- R2: When bit 12 is 0 and n = bits [11:8] is at least 1, the serial clock period is 2^n module clocks, that is, a half period of 2^(n-1). Bits [7:0] have no effect in this mode.
- R3: In the power-of-two mode, n = 0 is treated as a half period of one module clock.
- R4: While idle, the serial clock follows the polarity input, one module clock later. While bus enable is low, no edge and no strobe occurs, even when run request is high.
- R5: The first edge of each period moves the serial clock away from the polarity level. With phase 0, the sample strobe marks the first (leading) edge and the shift strobe marks the second (trailing) edge. With phase 1, the two are swapped.
- R6: Every serial clock change in a run carries exactly one strobe, and that strobe is high only in the module clock where the new level first appears. No strobe appears at any other time.
- R7: The divider fields are captured when a run starts. Changes to them during the run have no effect until the next start.
- R8: A run ends only at a trailing edge, and only when run request or bus enable is low in that clock. The serial clock then rests at the polarity level. If the request falls right after a trailing edge, one more full period follows.
- R9: The reset is synchronous. It forces the serial clock to the polarity level, clears both strobes, and returns the block to idle, so counting restarts from zero.
- R10: The first edge comes H module clocks after the clock edge that accepts the run request, where H is the half period. Each later edge follows the one before it by H module clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| divCtl | input | 13 | Divider control word: [7:0] linear field, [11:8] power field, [12] law select |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| busEn | input | 1 | Bus enable; no activity while low |
| runReq | input | 1 | Run request from the transfer engine, a level |
| sck | output | 1 | Serial clock |
| sampleStb | output | 1 | One-clock strobe at the sampling edge |
| shiftStb | output | 1 | One-clock strobe at the shifting edge |

## Verification
The stop decision and a trailing edge happen in the same module clock, so the two are tested together. The bench drops run request right after a leading edge and expects exactly one more edge. It also drops the request right after a trailing edge, where the decision to continue has already been taken, and expects two more edges before the clock rests at the polarity level. A divider field rewrite is made in the clock that follows the first edge of a run. The bench then checks that later edge spacing keeps the captured half period, and that the new value takes effect at the next start.

// File: rtl/sck_gen_pkg.sv
`timescale 1ns/1ps
package sck_gen_pkg;
  // Command passed from the control to the datapath every module clock
  typedef struct packed {
    logic active;   // a run is in progress
    logic load;     // a run starts in this clock
    logic edgeEv;   // the serial clock toggles at this edge
    logic leading;  // the toggle is the first of its period
  } sckCmd_t;
endpackage

// File: rtl/sck_gen_decode.sv
`timescale 1ns/1ps
module sck_gen_decode #(
  parameter int LIN_W  = 8,
  parameter int POW_W  = 4,
  parameter int CTL_W  = LIN_W + POW_W + 1,
  parameter int HALF_W = 14
) (
  input  logic [CTL_W-1:0]  divCtl,
  output logic [HALF_W-1:0] halfM1
);
  localparam int SEL_BIT = LIN_W + POW_W;

  logic [LIN_W-1:0] linVal;
  logic [POW_W-1:0] powVal;
  logic             useLin;
  logic [HALF_W-1:0] powHalf;

  assign linVal = divCtl[LIN_W-1:0];
  assign powVal = divCtl[LIN_W +: POW_W];
  assign useLin = divCtl[SEL_BIT];

  // Power law: half period 2^(n-1); n = 0 is taken as a half period of one
  always_comb begin
    if (powVal == '0) begin
      powHalf = '0;
    end else begin
      powHalf = (HALF_W'(1) << (powVal - POW_W'(1))) - HALF_W'(1);
    end
  end

  assign halfM1 = useLin ? HALF_W'(linVal) : powHalf;
endmodule

// File: rtl/sck_gen_ctrl.sv
`timescale 1ns/1ps
module sck_gen_ctrl
  import sck_gen_pkg::*;
#(
  parameter int HALF_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busEn,
  input  logic              runReq,
  input  logic [HALF_W-1:0] halfIn,
  output sckCmd_t           cmd
);
  logic              activeQ;
  logic              phaseQ;   // 0: next edge is leading, 1: next edge is trailing
  logic [HALF_W-1:0] cntQ;
  logic [HALF_W-1:0] halfQ;

  logic hit;
  logic startOk;
  logic stopNow;

  assign hit     = activeQ && (cntQ == halfQ);
  assign startOk = !activeQ && busEn && runReq;
  assign stopNow = hit && phaseQ && !(runReq && busEn);

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= 1'b0;
      phaseQ  <= 1'b0;
      cntQ    <= '0;
      halfQ   <= '0;
    end else if (startOk) begin
      activeQ <= 1'b1;
      phaseQ  <= 1'b0;
      cntQ    <= '0;
      halfQ   <= halfIn;
    end else if (activeQ) begin
      if (hit) begin
        cntQ   <= '0;
        phaseQ <= ~phaseQ;
        if (stopNow) begin
          activeQ <= 1'b0;
        end
      end else begin
        cntQ <= cntQ + HALF_W'(1);
      end
    end
  end

  assign cmd.active  = activeQ;
  assign cmd.load    = startOk;
  assign cmd.edgeEv  = hit;
  assign cmd.leading = !phaseQ;

  // R1: the counter never runs past the captured half period
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    activeQ |-> (cntQ <= halfQ));

  // R7: the captured divisor holds for the whole run
  p_div_held_r7: assert property (@(posedge clk) disable iff (rst)
    (activeQ && !stopNow) |=> $stable(halfQ));

  // R4: with the bus disabled an idle block stays idle
  p_bus_off_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!activeQ && !busEn) |=> !activeQ);

  // R8: a run only ends right after a trailing edge
  p_stop_on_trailing_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(activeQ) |-> $past(hit && phaseQ));
endmodule

// File: rtl/sck_gen_dp.sv
`timescale 1ns/1ps
module sck_gen_dp
  import sck_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cpol,
  input  logic    cpha,
  input  sckCmd_t cmd,
  output logic    sck,
  output logic    sampleStb,
  output logic    shiftStb
);
  logic sckQ;
  logic cphaQ;
  logic sampleQ;
  logic shiftQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      sckQ    <= cpol;
      cphaQ   <= 1'b0;
      sampleQ <= 1'b0;
      shiftQ  <= 1'b0;
    end else begin
      sampleQ <= 1'b0;
      shiftQ  <= 1'b0;
      if (cmd.load) begin
        sckQ  <= cpol;
        cphaQ <= cpha;
      end else if (cmd.active) begin
        if (cmd.edgeEv) begin
          sckQ    <= ~sckQ;
          sampleQ <= (cmd.leading != cphaQ);
          shiftQ  <= (cmd.leading == cphaQ);
        end
      end else begin
        sckQ <= cpol;
      end
    end
  end

  assign sck       = sckQ;
  assign sampleStb = sampleQ;
  assign shiftStb  = shiftQ;

  // R5: never both strobes at once
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sampleQ, shiftQ}));

  // R6: a strobe marks a clock where the serial clock just changed
  p_strobe_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (sampleQ || shiftQ) |-> (sckQ != $past(sckQ)));

  // R6: every change during a run carries a strobe
  p_edge_has_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd.active) && !$past(cmd.load) && (sckQ != $past(sckQ)))
      |-> (sampleQ || shiftQ));

  // R6: a sample strobe lasts one module clock
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    sampleQ |=> !sampleQ);
endmodule

// File: rtl/spi_sck_gen.sv
`timescale 1ns/1ps
module spi_sck_gen
  import sck_gen_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int CTL_W = LIN_W + POW_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] divCtl,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             busEn,
  input  logic             runReq,
  output logic             sck,
  output logic             sampleStb,
  output logic             shiftStb
);
  // Largest half period minus one: 2^(2^POW_W - 2) - 1 or 2^LIN_W - 1
  localparam int POW_HB = (2 ** POW_W) - 2;
  localparam int HALF_W = (POW_HB > LIN_W) ? POW_HB : LIN_W;

  logic [HALF_W-1:0] halfM1;
  sckCmd_t           cmd;

  sck_gen_decode #(
    .LIN_W (LIN_W),
    .POW_W (POW_W),
    .CTL_W (CTL_W),
    .HALF_W(HALF_W)
  ) u_decode (
    .divCtl(divCtl),
    .halfM1(halfM1)
  );

  sck_gen_ctrl #(
    .HALF_W(HALF_W)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .busEn (busEn),
    .runReq(runReq),
    .halfIn(halfM1),
    .cmd   (cmd)
  );

  sck_gen_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .cpol     (cpol),
    .cpha     (cpha),
    .cmd      (cmd),
    .sck      (sck),
    .sampleStb(sampleStb),
    .shiftStb (shiftStb)
  );
endmodule

// File: tb/spi_sck_gen_bench.sv
`timescale 1ns/1ps
module spi_sck_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] divCtl;
  logic        cpol, cpha, busEn, runReq;
  logic        sck, sampleStb, shiftStb;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_sck_gen u_spi_sck_gen (
    .clk(clk), .rst(rst), .divCtl(divCtl), .cpol(cpol), .cpha(cpha),
    .busEn(busEn), .runReq(runReq), .sck(sck),
    .sampleStb(sampleStb), .shiftStb(shiftStb)
  );

  // Unused field filled with a pattern to show it has no effect
  function automatic logic [12:0] linCtl(input int v);
    return {1'b1, 4'hC, 8'(v)};
  endfunction
  function automatic logic [12:0] powCtl(input int n);
    return {1'b0, 4'(n), 8'hA5};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Starts a run at a falling edge and follows it for nEdges serial clock edges
  task automatic runEdges(input int expH, input int nEdges, input string req,
                          input bit doSwap, input logic [12:0] swapCtl);
    int   t = 0;
    int   found = 0;
    int   lastT = 0;
    int   badGap = 0, badFirst = 0, badStb = 0, badQuiet = 0, badLvl = 0;
    logic prev;
    logic pol;
    logic ph;
    logic expSample;
    prev = sck;
    pol  = cpol;
    ph   = cpha;
    runReq = 1'b1;
    while (found < nEdges && t < expH * (nEdges + 2) + 10) begin
      @(negedge clk);
      t++;
      if (sck !== prev) begin
        found++;
        if (found == 1) begin
          if (t != expH + 1) badFirst++;
          if (sck !== ~pol) badLvl++;
          if (doSwap) divCtl = swapCtl;
        end else if (t - lastT != expH) begin
          badGap++;
        end
        lastT = t;
        expSample = (found % 2 == 1) ^ ph;
        if (sampleStb !== expSample || shiftStb !== !expSample) badStb++;
      end else if (sampleStb || shiftStb) begin
        badQuiet++;
      end
      prev = sck;
    end
    chk(found == nEdges, req, "edge count", found, nEdges);
    chk(badFirst == 0, "R10", "first edge latency errors", badFirst, 0);
    chk(badGap == 0, req, "edge spacing errors", badGap, 0);
    chk(badStb == 0, "R5", "strobe kind errors", badStb, 0);
    chk(badQuiet == 0, "R6", "strobes away from edges", badQuiet, 0);
    chk(badLvl == 0, "R5", "first edge direction errors", badLvl, 0);
  endtask

  task automatic countEdges(input int window, output int n);
    logic prev;
    n = 0;
    prev = sck;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (sck !== prev) n++;
      prev = sck;
    end
  endtask

  // Ends a run and checks the remaining edges and the resting level
  task automatic finish(input int expExtra, input int expH, input string req);
    int n;
    runReq = 1'b0;
    countEdges(4 * expH + 6, n);
    chk(n == expExtra, req, "edges after stop", n, expExtra);
    chk(sck === cpol, req, "resting level", int'(sck), int'(cpol));
  endtask

  task automatic t_linear();
    int vals[3] = '{0, 2, 255};
    cpol = 1'b0; cpha = 1'b0; busEn = 1'b1;
    foreach (vals[i]) begin
      divCtl = linCtl(vals[i]);
      runEdges(vals[i] + 1, 3, "R1", 1'b0, '0);
      finish(1, vals[i] + 1, "R8");
    end
  endtask

  task automatic t_power();
    int ns[3] = '{1, 3, 6};
    cpol = 1'b1; cpha = 1'b0; busEn = 1'b1;
    @(negedge clk);
    foreach (ns[i]) begin
      divCtl = powCtl(ns[i]);
      runEdges(1 << (ns[i] - 1), 3, "R2", 1'b0, '0);
      finish(1, 1 << (ns[i] - 1), "R8");
    end
    divCtl = powCtl(0);
    runEdges(1, 3, "R3", 1'b0, '0);
    finish(1, 1, "R8");
  endtask

  task automatic t_phase();
    busEn = 1'b1;
    cpol = 1'b0; cpha = 1'b1;
    @(negedge clk);
    divCtl = linCtl(1);
    runEdges(2, 5, "R5", 1'b0, '0);
    finish(1, 2, "R8");
    cpol = 1'b1;
    @(negedge clk);
    divCtl = powCtl(2);
    runEdges(2, 3, "R5", 1'b0, '0);
    finish(1, 2, "R8");
    cpha = 1'b0;
  endtask

  task automatic t_stopTrail();
    int n;
    cpol = 1'b0; busEn = 1'b1;
    @(negedge clk);
    divCtl = linCtl(2);
    runEdges(3, 4, "R8", 1'b0, '0);
    finish(2, 3, "R8");
    // bus enable falling after a leading edge
    runEdges(3, 1, "R8", 1'b0, '0);
    busEn = 1'b0;
    countEdges(20, n);
    chk(n == 1, "R8", "edges after bus disable", n, 1);
    chk(sck === cpol, "R8", "level after bus disable", int'(sck), int'(cpol));
    runReq = 1'b0;
    busEn  = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_busOff();
    int n;
    busEn = 1'b0; runReq = 1'b1; cpol = 1'b0;
    divCtl = linCtl(0);
    countEdges(40, n);
    chk(n == 0, "R4", "edges with bus disabled", n, 0);
    cpol = 1'b1;
    @(negedge clk);
    chk(sck === 1'b1, "R4", "idle level follows polarity", int'(sck), 1);
    countEdges(30, n);
    chk(n == 0, "R4", "edges with bus disabled, high polarity", n, 0);
    runReq = 1'b0; busEn = 1'b1; cpol = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latch();
    cpol = 1'b0; cpha = 1'b0; busEn = 1'b1;
    divCtl = linCtl(3);
    runEdges(4, 4, "R7", 1'b1, linCtl(0));
    finish(2, 4, "R8");
    runEdges(1, 3, "R7", 1'b0, '0);
    finish(1, 1, "R8");
  endtask

  task automatic t_reset();
    cpol = 1'b0; busEn = 1'b1;
    divCtl = linCtl(7);
    runEdges(8, 1, "R9", 1'b0, '0);
    rst = 1'b1;
    @(negedge clk);
    chk(sck === 1'b0, "R9", "level in reset", int'(sck), 0);
    chk(!(sampleStb || shiftStb), "R9", "strobes in reset",
        int'(sampleStb) + int'(shiftStb), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    runEdges(8, 3, "R9", 1'b0, '0);
    finish(1, 8, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; divCtl = '0; cpol = 1'b0; cpha = 1'b0;
    busEn = 1'b0; runReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(sck === 1'b0, "R9", "level after reset", int'(sck), 0);
    chk(!(sampleStb || shiftStb), "R9", "strobes after reset",
        int'(sampleStb) + int'(shiftStb), 0);
    rst = 1'b0;
    @(negedge clk);
    t_busOff();
    t_linear();
    t_power();
    t_phase();
    t_stopTrail();
    t_latch();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule